// File: doc/BRIEF.md
# Per-Warp Memory Transaction ID Manager

This block hands out and takes back the transaction IDs that tag outstanding global-memory loads and stores. Each warp has its own pool of 64 slots. The slot numbers sit in a per-warp free queue that reset fills in ascending order. Each warp also has a table of in-flight entries. Each entry holds the destination register, the active-thread mask, the access address and whether the access is a store. When a warp issues a memory access, the manager takes the slot at the head of that warp's queue in the same cycle and returns a 16-bit ID. The ID packs the slot, the warp and a fixed core number. If the queue is empty, the request is refused and the warp has to stall.

Responses may come back in any order. A response carries only the ID. The manager looks up the matching entry and, one cycle later, presents the stored destination, mask, address and kind for writeback. For a load it also pulses a scoreboard-clear strobe. It then invalidates the entry and appends the slot to the tail of that warp's free queue. A store acknowledgement completes in the same way but does not clear the scoreboard. An ID that matches no live entry produces a one-cycle error pulse and changes nothing.

Top module: `mshr_txn_mgr`

## Requirements
- R1: After reset every warp has all 64 slots free, no completion, scoreboard-clear or error output is active, and the first grant to any warp uses slot 0.
- R2: A granted ID carries the slot in bits [5:0], the warp in bits [9:6] and the SM_ID parameter in bits [15:10]. With SM_ID 0, warp 0 drawing slot 16 gives 0x0010.
- R3: An issue is granted in the same cycle it is requested whenever the warp has a free slot. A warp holds at most 64 live IDs, and a request made while all 64 are live is refused.
- R4: A response to a live ID produces, in the next cycle, a one-cycle completion that carries the warp, destination register, mask, address and store flag recorded at issue.
- R5: A completion for a load also pulses the scoreboard-clear output. A completion for a store (the write acknowledgement) does not.
- R6: A freed slot joins the tail of its warp's free queue, so slots are handed out again in the order they were freed, after those already queued.
- R7: Responses may arrive in any order relative to issue, and each returns its own entry.
- R8: A response whose ID has a different core number, a warp at or above NUM_WARPS, or a slot that is not live produces a one-cycle error pulse in the next cycle, gives no completion and frees nothing.
- R9: An issue and a response for the same warp in the same cycle are both accepted. The slot freed in that cycle can first be granted in the following cycle.
- R10: Warps are independent: using up or freeing the slots of one warp does not change the grants or IDs of another warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid_i | input | 1 | Issue request |
| iss_warp_i | input | 4 | Warp making the request |
| iss_rd_i | input | RD_W | Destination register index |
| iss_mask_i | input | MASK_W | Active thread mask |
| iss_addr_i | input | ADDR_W | Access address |
| iss_store_i | input | 1 | Access is a store |
| iss_grant_o | output | 1 | Request accepted this cycle |
| iss_txn_o | output | 16 | Granted transaction ID |
| rsp_valid_i | input | 1 | Response or store acknowledgement arrives |
| rsp_txn_i | input | 16 | ID carried by the response |
| cmp_valid_o | output | 1 | Completion for writeback |
| cmp_warp_o | output | 4 | Warp of the completion |
| cmp_rd_o | output | RD_W | Destination register of the completion |
| cmp_mask_o | output | MASK_W | Thread mask of the completion |
| cmp_addr_o | output | ADDR_W | Address of the completion |
| cmp_store_o | output | 1 | Completion was a store |
| sb_clr_o | output | 1 | Scoreboard-clear pulse for cmp_rd_o |
| rsp_err_o | output | 1 | Response ID matched no live entry |

## Verification
The bench first drains one warp in long runs, which shows the ascending order after reset and the exact packing of the ID fields. It then frees slots in a scrambled order and draws them again, which separates a true tail-append queue from a lowest-free-slot search. It sends stale and foreign IDs and then retires the same entries legally, which shows whether a rejected response left state behind. Issue and response in the same cycle are applied both to a full warp and to a warp with slots free, which shows the one-cycle gap before a freed slot can be granted again.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
    localparam int SLOT_FW   = 6;
    localparam int WARP_FW   = 4;
    localparam int SM_FW     = 6;
    localparam int TXN_W     = SLOT_FW + WARP_FW + SM_FW;
    localparam int SLOTS     = 1 << SLOT_FW;
    localparam int WARP_SPAN = 1 << WARP_FW;

    function automatic logic [TXN_W-1:0] txn_pack(input logic [SM_FW-1:0] sm,
                                                  input logic [WARP_FW-1:0] warp,
                                                  input logic [SLOT_FW-1:0] slot);
        return {sm, warp, slot};
    endfunction
endpackage

// File: rtl/mshr_free_fifo.sv
module mshr_free_fifo #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_i,
    input  logic             push_i,
    input  logic [IDX_W-1:0] push_idx_i,
    output logic [IDX_W-1:0] head_o,
    output logic             nonempty_o
);
    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0] mem;
        logic [IDX_W-1:0]            rd_ptr;
        logic [IDX_W-1:0]            wr_ptr;
        logic [IDX_W:0]              count;
    } fifo_t;

    fifo_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (pop_i) s_d.rd_ptr = s_q.rd_ptr + 1'b1;
        if (push_i) begin
            s_d.mem[s_q.wr_ptr] = push_idx_i;
            s_d.wr_ptr          = s_q.wr_ptr + 1'b1;
        end
        s_d.count = s_q.count + {{IDX_W{1'b0}}, push_i} - {{IDX_W{1'b0}}, pop_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) s_q.mem[i] <= IDX_W'(i);
            s_q.rd_ptr <= '0;
            s_q.wr_ptr <= '0;
            s_q.count  <= (IDX_W+1)'(DEPTH);
        end else begin
            s_q <= s_d;
        end
    end

    assign head_o     = s_q.mem[s_q.rd_ptr];
    assign nonempty_o = (s_q.count != '0);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && !pop_i |-> s_q.count < (IDX_W+1)'(DEPTH));
    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> s_q.count != '0);
endmodule

// File: rtl/mshr_slot_table.sv
module mshr_slot_table #(
    parameter int DEPTH = 64,
    parameter int PAY_W = 73,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic [IDX_W-1:0] alloc_idx_i,
    input  logic [PAY_W-1:0] alloc_pay_i,
    input  logic             free_i,
    input  logic [IDX_W-1:0] look_idx_i,
    output logic [DEPTH-1:0] live_o,
    output logic [PAY_W-1:0] look_pay_o
);
    logic [DEPTH-1:0] live_d, live_q;
    logic [PAY_W-1:0] pay_q [DEPTH];

    always_comb begin
        live_d = live_q;
        if (free_i)  live_d[look_idx_i]  = 1'b0;
        if (alloc_i) live_d[alloc_idx_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    always_ff @(posedge clk) begin
        if (alloc_i) pay_q[alloc_idx_i] <= alloc_pay_i;
    end

    assign live_o     = live_q;
    assign look_pay_o = pay_q[look_idx_i];

    // R3
    no_double_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !live_q[alloc_idx_i]);
    // R4
    free_live_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_i |-> live_q[look_idx_i]);
    // R6
    free_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_i |=> !live_q[$past(look_idx_i)]);
    // R3
    alloc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |=> live_q[$past(alloc_idx_i)]);
endmodule

// File: rtl/mshr_txn_mgr.sv
module mshr_txn_mgr
    import mshr_pkg::*;
#(
    parameter int                NUM_WARPS = 4,
    parameter logic [SM_FW-1:0]  SM_ID     = '0,
    parameter int                RD_W      = 8,
    parameter int                MASK_W    = 32,
    parameter int                ADDR_W    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               iss_valid_i,
    input  logic [WARP_FW-1:0] iss_warp_i,
    input  logic [RD_W-1:0]    iss_rd_i,
    input  logic [MASK_W-1:0]  iss_mask_i,
    input  logic [ADDR_W-1:0]  iss_addr_i,
    input  logic               iss_store_i,
    output logic               iss_grant_o,
    output logic [TXN_W-1:0]   iss_txn_o,
    input  logic               rsp_valid_i,
    input  logic [TXN_W-1:0]   rsp_txn_i,
    output logic               cmp_valid_o,
    output logic [WARP_FW-1:0] cmp_warp_o,
    output logic [RD_W-1:0]    cmp_rd_o,
    output logic [MASK_W-1:0]  cmp_mask_o,
    output logic [ADDR_W-1:0]  cmp_addr_o,
    output logic               cmp_store_o,
    output logic               sb_clr_o,
    output logic               rsp_err_o
);
    localparam int PAY_W = 1 + ADDR_W + MASK_W + RD_W;

    typedef struct packed {
        logic               cmp_valid;
        logic               sb_clr;
        logic               err;
        logic [WARP_FW-1:0] warp;
        logic [RD_W-1:0]    rd;
        logic [MASK_W-1:0]  mask;
        logic [ADDR_W-1:0]  addr;
        logic               store;
    } out_t;

    logic [SLOT_FW-1:0] rsp_slot;
    logic [WARP_FW-1:0] rsp_warp;
    logic [SM_FW-1:0]   rsp_sm;
    assign {rsp_sm, rsp_warp, rsp_slot} = rsp_txn_i;

    logic [WARP_SPAN-1:0] fifo_nonempty;
    logic [SLOT_FW-1:0]   fifo_head [WARP_SPAN];
    logic [SLOTS-1:0]     tbl_live  [WARP_SPAN];
    logic [PAY_W-1:0]     tbl_pay   [WARP_SPAN];

    logic rsp_hit;
    logic [PAY_W-1:0] iss_pay;

    assign iss_grant_o = iss_valid_i && fifo_nonempty[iss_warp_i];
    assign iss_txn_o   = txn_pack(SM_ID, iss_warp_i, fifo_head[iss_warp_i]);
    assign iss_pay     = {iss_store_i, iss_addr_i, iss_mask_i, iss_rd_i};
    assign rsp_hit     = rsp_valid_i && (rsp_sm == SM_ID) && tbl_live[rsp_warp][rsp_slot];

    for (genvar w = 0; w < WARP_SPAN; w++) begin : g_warp
        if (w < NUM_WARPS) begin : g_live
            logic take, give;
            assign take = iss_grant_o && (iss_warp_i == WARP_FW'(w));
            assign give = rsp_hit && (rsp_warp == WARP_FW'(w));

            mshr_free_fifo #(.DEPTH(SLOTS)) u_free (
                .clk        (clk),
                .rst_n      (rst_n),
                .pop_i      (take),
                .push_i     (give),
                .push_idx_i (rsp_slot),
                .head_o     (fifo_head[w]),
                .nonempty_o (fifo_nonempty[w])
            );

            mshr_slot_table #(.DEPTH(SLOTS), .PAY_W(PAY_W)) u_tbl (
                .clk         (clk),
                .rst_n       (rst_n),
                .alloc_i     (take),
                .alloc_idx_i (fifo_head[w]),
                .alloc_pay_i (iss_pay),
                .free_i      (give),
                .look_idx_i  (rsp_slot),
                .live_o      (tbl_live[w]),
                .look_pay_o  (tbl_pay[w])
            );
        end else begin : g_none
            assign fifo_nonempty[w] = 1'b0;
            assign fifo_head[w]     = '0;
            assign tbl_live[w]      = '0;
            assign tbl_pay[w]       = '0;
        end
    end

    out_t o_d, o_q;

    always_comb begin
        o_d           = '0;
        o_d.cmp_valid = rsp_hit;
        o_d.err       = rsp_valid_i && !rsp_hit;
        if (rsp_hit) begin
            o_d.warp = rsp_warp;
            {o_d.store, o_d.addr, o_d.mask, o_d.rd} = tbl_pay[rsp_warp];
            o_d.sb_clr = !o_d.store;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign cmp_valid_o = o_q.cmp_valid;
    assign cmp_warp_o  = o_q.warp;
    assign cmp_rd_o    = o_q.rd;
    assign cmp_mask_o  = o_q.mask;
    assign cmp_addr_o  = o_q.addr;
    assign cmp_store_o = o_q.store;
    assign sb_clr_o    = o_q.sb_clr;
    assign rsp_err_o   = o_q.err;

    // R8
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> !cmp_valid_o);
    // R5
    sbclr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_clr_o |-> cmp_valid_o && !cmp_store_o);
    // R8
    foreign_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i && (rsp_sm != SM_ID) |=> rsp_err_o && !cmp_valid_o);
    // R4
    rsp_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i |=> cmp_valid_o || rsp_err_o);
    // R10
    warp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant_o |-> 32'(iss_warp_i) < NUM_WARPS);
endmodule

// File: tb/mshr_txn_mgr_bench.sv
module mshr_txn_mgr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_warp = '0;
    logic [7:0]  iss_rd = '0;
    logic [31:0] iss_mask = '0;
    logic [31:0] iss_addr = '0;
    logic        iss_store = 1'b0;
    logic        iss_grant;
    logic [15:0] iss_txn;
    logic        rsp_valid = 1'b0;
    logic [15:0] rsp_txn = '0;
    logic        cmp_valid, cmp_store, sb_clr, rsp_err;
    logic [3:0]  cmp_warp;
    logic [7:0]  cmp_rd;
    logic [31:0] cmp_mask, cmp_addr;

    always #2.5 clk = ~clk;

    mshr_txn_mgr u_mshr_txn_mgr (
        .clk(clk), .rst_n(rst_n),
        .iss_valid_i(iss_valid), .iss_warp_i(iss_warp), .iss_rd_i(iss_rd),
        .iss_mask_i(iss_mask), .iss_addr_i(iss_addr), .iss_store_i(iss_store),
        .iss_grant_o(iss_grant), .iss_txn_o(iss_txn),
        .rsp_valid_i(rsp_valid), .rsp_txn_i(rsp_txn),
        .cmp_valid_o(cmp_valid), .cmp_warp_o(cmp_warp), .cmp_rd_o(cmp_rd),
        .cmp_mask_o(cmp_mask), .cmp_addr_o(cmp_addr), .cmp_store_o(cmp_store),
        .sb_clr_o(sb_clr), .rsp_err_o(rsp_err)
    );

    int n_run = 0;
    int n_fail = 0;
    int serial = 1;
    logic [7:0]  exp_rd   [16][64];
    logic [31:0] exp_mask [16][64];
    logic [31:0] exp_addr [16][64];
    logic        exp_st   [16][64];

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, sample grant before the edge, return at next negedge
    task automatic cycle(input logic iv, input logic [3:0] w, input logic st,
                         input logic rv, input logic [15:0] rid,
                         output logic g, output logic [15:0] id);
        iss_valid = iv; iss_warp = w; iss_store = st;
        iss_rd = serial[7:0]; iss_mask = {serial[15:0], ~serial[15:0]};
        iss_addr = 32'h8000_0000 + 32'(serial) * 4;
        rsp_valid = rv; rsp_txn = rid;
        #1;
        g = iss_grant; id = iss_txn;
        if (iv && g) begin
            exp_rd[w][id[5:0]] = iss_rd; exp_mask[w][id[5:0]] = iss_mask;
            exp_addr[w][id[5:0]] = iss_addr; exp_st[w][id[5:0]] = st;
            serial++;
        end
        @(posedge clk); #1;
        iss_valid = 1'b0; rsp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic issue_expect(input logic [3:0] w, input logic st, input logic [15:0] exp_id, input string req);
        logic g; logic [15:0] id;
        cycle(1'b1, w, st, 1'b0, 16'h0, g, id);
        chk(g === 1'b1, req, {63'h0, g}, 64'h1);
        chk(id === exp_id, req, {48'h0, id}, {48'h0, exp_id});
    endtask

    task automatic check_cmp(input logic [15:0] id, input string req);
        logic [3:0] w; logic [5:0] s;
        w = id[9:6]; s = id[5:0];
        chk(cmp_valid === 1'b1 && rsp_err === 1'b0, req, {62'h0, cmp_valid, rsp_err}, 64'h2);
        chk(cmp_warp === w && cmp_rd === exp_rd[w][s], req, {52'h0, cmp_warp, cmp_rd}, {52'h0, w, exp_rd[w][s]});
        chk(cmp_mask === exp_mask[w][s] && cmp_addr === exp_addr[w][s], req,
            {cmp_mask, cmp_addr}, {exp_mask[w][s], exp_addr[w][s]});
        chk(cmp_store === exp_st[w][s] && sb_clr === !exp_st[w][s], req,
            {62'h0, cmp_store, sb_clr}, {62'h0, exp_st[w][s], !exp_st[w][s]});
    endtask

    task automatic respond_ok(input logic [15:0] id, input string req);
        logic g; logic [15:0] d;
        cycle(1'b0, 4'h0, 1'b0, 1'b1, id, g, d);
        check_cmp(id, req);
    endtask

    task automatic respond_bad(input logic [15:0] id, input string req);
        logic g; logic [15:0] d;
        cycle(1'b0, 4'h0, 1'b0, 1'b1, id, g, d);
        chk(rsp_err === 1'b1 && cmp_valid === 1'b0 && sb_clr === 1'b0, req,
            {61'h0, rsp_err, cmp_valid, sb_clr}, 64'h4);
    endtask

    task automatic test_reset();
        chk(cmp_valid === 1'b0 && sb_clr === 1'b0 && rsp_err === 1'b0, "R1 idle outputs",
            {61'h0, cmp_valid, sb_clr, rsp_err}, 64'h0);
        issue_expect(4'd0, 1'b0, 16'h0000, "R1 first grant slot 0");
    endtask

    task automatic test_id_format();
        for (int i = 1; i < 16; i++) issue_expect(4'd0, 1'b0, 16'(i), "R2 ascending slots");
        issue_expect(4'd0, 1'b0, 16'h0010, "R2 warp0 slot16 id");
        issue_expect(4'd2, 1'b0, 16'h0080, "R2 warp field");
    endtask

    task automatic test_load_rsp();
        respond_ok(16'h0003, "R4 R5 load completion");
        chk(1'b1, "R4", 64'h0, 64'h0);
    endtask

    task automatic test_store_rsp();
        issue_expect(4'd1, 1'b1, 16'h0040, "R5 store issue");
        respond_ok(16'h0040, "R5 store ack no sb clear");
    endtask

    task automatic test_ooo();
        respond_ok(16'h000A, "R7 out of order 10");
        respond_ok(16'h0005, "R7 out of order 5");
        respond_ok(16'h000C, "R7 out of order 12");
    endtask

    task automatic test_bad_rsp();
        respond_bad(16'h0003, "R8 stale slot");
        respond_bad(16'h01C0, "R8 warp out of range");
        respond_bad(16'h0401, "R8 foreign core");
        respond_ok(16'h0001, "R8 entry untouched by foreign id");
    endtask

    task automatic test_recycle();
        // free queue of warp 0 now: 17..63, then 3, 10, 5, 12, 1
        for (int i = 17; i < 64; i++) issue_expect(4'd0, 1'b0, 16'(i), "R6 queued slots first");
        issue_expect(4'd0, 1'b0, 16'h0003, "R6 first freed slot");
        issue_expect(4'd0, 1'b0, 16'h000A, "R6 second freed slot");
    endtask

    task automatic test_exhaust();
        logic g; logic [15:0] id;
        for (int i = 0; i < 64; i++) issue_expect(4'd3, 1'b0, 16'h00C0 | 16'(i), "R3 fill warp 3");
        cycle(1'b1, 4'd3, 1'b0, 1'b0, 16'h0, g, id);
        chk(g === 1'b0, "R3 65th refused", {63'h0, g}, 64'h0);
    endtask

    task automatic test_same_cycle();
        logic g; logic [15:0] id;
        cycle(1'b1, 4'd3, 1'b0, 1'b1, 16'h00D4, g, id);
        chk(g === 1'b0, "R9 freed slot not granted same cycle", {63'h0, g}, 64'h0);
        check_cmp(16'h00D4, "R9 response accepted on full warp");
        issue_expect(4'd3, 1'b0, 16'h00D4, "R9 freed slot granted next cycle");
        cycle(1'b1, 4'd0, 1'b0, 1'b1, 16'h0000, g, id);
        chk(g === 1'b1 && id === 16'h0005, "R9 issue with response", {47'h0, g, id}, {47'h0, 1'b1, 16'h0005});
        check_cmp(16'h0000, "R9 response with issue");
    endtask

    task automatic test_warp_indep();
        issue_expect(4'd2, 1'b0, 16'h0081, "R10 warp 2 unaffected");
        issue_expect(4'd1, 1'b0, 16'h0041, "R10 warp 1 own queue");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_id_format();
        test_load_rsp();
        test_store_rsp();
        test_ooo();
        test_bad_rsp();
        test_recycle();
        test_exhaust();
        test_same_cycle();
        test_warp_indep();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule